// File: doc/BRIEF.md
# Multicycle 16-bit Processor Core

This block is a small von Neumann processor. It has one shared memory of 256 words of 16 bits, an 8-bit program counter, seven general registers R0 to R6 and a 4-bit flag register. The flag register is read as register index 7. While reset is held low, a load port writes the program and its data into memory word by word. Once reset is released, the core fetches from word 0. It runs each instruction through a fetch, an execute and a writeback cycle, and it continues until it retires a halt or an undefined opcode.

After every retired instruction the core pulses a trace strobe for one cycle. The strobe comes with the address of that instruction and a snapshot of all eight registers. A second memory read port lets a test harness dump memory contents after the core has stopped. The core is meant as an architectural reference engine: a harness can compare its trace, line by line, with a software model of the same instruction set.

Top module: `mc16_core`

## Requirements
- R1: While rst_n is low, halted, illegal and trace_valid are 0 and every register reads 0. The first instruction retired after release is the one at word 0.
- R2: The load port writes load_data to word load_addr on each clock edge while rst_n is low and load_en is 1. While rst_n is high, the load port has no effect on memory.
- R3: Each instruction takes exactly three clock cycles. The trace strobe trace_valid is high for one cycle per retired instruction. trace_pc is that instruction's address, and trace_regs holds the state after it, with register k (R0..R6, FLAGS as 7) in bits 16k+15:16k.
- R4: Opcode 00000 (add), 00001 (subtract) and 00110 (multiply) write reg[8:6] = reg[5:3] op reg[2:0], keeping the low 16 bits. The overflow flag V is FLAGS bit 3 and is set on carry out, on a non-zero upper product half, or when a subtraction would go negative. In that last case the destination receives 0.
- R5: Opcode 00010 writes the register in bits 10:8 with the 8-bit value in bits 7:0, zero-extended. Opcode 00011 copies reg[2:0] into reg[5:3], and a source field of 111 reads FLAGS.
- R6: Opcodes 01010, 01011 and 01100 write reg[8:6] with the XOR, OR or AND of reg[5:3] and reg[2:0]. Opcode 01101 writes reg[5:3] with the inverse of reg[2:0]. Opcodes 01000 and 01001 shift the register in bits 10:8 right or left by the 8-bit amount in bits 7:0, filling with zeros.
- R7: Opcode 00111 writes R0 with reg[5:3] divided by reg[2:0] and R1 with the remainder. A zero divisor writes 0 to both and sets V.
- R8: Opcode 01110 compares reg[5:3] with reg[2:0] and sets exactly one of L (bit 2, less), G (bit 1, greater) or E (bit 0, equal).
- R9: Every instruction except add, subtract, multiply, divide and compare leaves FLAGS at 0 after it retires. This includes jumps, moves (even a move that reads FLAGS) and halt.
- R10: Opcode 00100 loads the word addressed by bits 7:0 into the register in bits 10:8. Opcode 00101 stores that register into the addressed word. One address selects one 16-bit word.
- R11: Opcode 01111 jumps to bits 7:0. Opcodes 10000, 10001 and 10010 jump only if L, G or E was set by the previous instruction. All other instructions advance the PC by 1 modulo 256.
- R12: Opcode 10011 retires with a trace line and then raises halted. After that no further trace strobes or memory writes occur until reset.
- R13: An opcode from 10100 to 11111 retires like halt, changes no general register and also raises illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; memory loading happens while low |
| load_en | input | 1 | Write strobe of the load port, honoured only in reset |
| load_addr | input | 8 | Word address for the load port |
| load_data | input | 16 | Word written by the load port |
| dump_addr | input | 8 | Word address of the dump read port |
| dump_data | output | 16 | Memory word at dump_addr, combinational |
| trace_valid | output | 1 | One-cycle strobe per retired instruction |
| trace_pc | output | 8 | Address of the instruction just retired |
| trace_regs | output | 128 | R0..R6 and FLAGS after that instruction, R0 in the low bits |
| halted | output | 1 | Core has stopped on halt or an undefined opcode |
| illegal | output | 1 | The stop was caused by an undefined opcode |

## Verification
Some properties are checked on every cycle by the assertions: the strobe lasting a single cycle and coming only out of the writeback state, halted holding with no trace and no store behind it, illegal implying halted, and FLAGS never carrying more than one compare bit or any bit above bit 3. The values themselves can only be shown by the bench's directed programs: arithmetic results and their overflow cases, the divide-by-zero rule, which branch is taken, PC wraparound, the load and store contents read back through the dump port, and the load port being ignored once the core runs.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int WORD_W   = 16;
  localparam int ADDR_W   = 8;
  localparam int RIDX_W   = 3;
  localparam int NREGS    = 1 << RIDX_W;
  localparam int FLAG_IDX = NREGS - 1;
  localparam int QUOT_IDX = 0;
  localparam int REM_IDX  = 1;
  localparam int FLAG_W   = 4;
  localparam int FL_V = 3, FL_L = 2, FL_G = 1, FL_E = 0;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [RIDX_W-1:0] ridx_t;

  localparam logic [4:0] OP_ADD = 5'b00000, OP_SUB = 5'b00001, OP_MOVI = 5'b00010,
                         OP_MOVR = 5'b00011, OP_LD = 5'b00100, OP_ST = 5'b00101,
                         OP_MUL = 5'b00110, OP_DIV = 5'b00111, OP_SHR = 5'b01000,
                         OP_SHL = 5'b01001, OP_XOR = 5'b01010, OP_OR = 5'b01011,
                         OP_AND = 5'b01100, OP_INV = 5'b01101, OP_CMP = 5'b01110,
                         OP_JMP = 5'b01111, OP_JLT = 5'b10000, OP_JGT = 5'b10001,
                         OP_JEQ = 5'b10010, OP_HLT = 5'b10011;

  // Everything the writeback cycle commits, computed one cycle earlier.
  typedef struct packed {
    logic              we_a;
    ridx_t             wa;
    word_t             da;
    logic              we_b;
    word_t             db;
    logic [FLAG_W-1:0] flags;
    logic              st_en;
    addr_t             st_addr;
    word_t             st_data;
    addr_t             npc;
    logic              stop;
    logic              bad;
  } commit_t;

  // {carry, sum}
  function automatic logic [WORD_W:0] fn_add(word_t a, word_t b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  // {underflow, difference}; clamps to zero when b exceeds a
  function automatic logic [WORD_W:0] fn_sub(word_t a, word_t b);
    if (b > a) return {1'b1, {WORD_W{1'b0}}};
    return {1'b0, a - b};
  endfunction

  // {upper half non-zero, low half}
  function automatic logic [WORD_W:0] fn_mul(word_t a, word_t b);
    logic [2*WORD_W-1:0] p;
    p = {{WORD_W{1'b0}}, a} * {{WORD_W{1'b0}}, b};
    return {|p[2*WORD_W-1:WORD_W], p[WORD_W-1:0]};
  endfunction

  // {divide by zero, quotient, remainder}
  function automatic logic [2*WORD_W:0] fn_div(word_t a, word_t b);
    if (b == '0) return {1'b1, {2*WORD_W{1'b0}}};
    return {1'b0, a / b, a % b};
  endfunction

  function automatic logic [FLAG_W-1:0] fn_cmp(word_t a, word_t b);
    return {1'b0, a < b, a > b, a == b};
  endfunction
endpackage

// File: rtl/mc16_mem.sv
module mc16_mem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata_a = cells[raddr_a];
  assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile
  import mc16_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  ridx_t                   rd_a_idx,
  output word_t                   rd_a,
  input  ridx_t                   rd_b_idx,
  output word_t                   rd_b,
  input  ridx_t                   rd_c_idx,
  output word_t                   rd_c,
  input  logic                    wr_a_en,
  input  ridx_t                   wr_a_idx,
  input  word_t                   wr_a_data,
  input  logic                    wr_b_en,
  input  word_t                   wr_b_data,
  input  logic                    fl_en,
  input  logic [FLAG_W-1:0]       fl_data,
  output logic [FLAG_W-1:0]       flags,
  output logic [NREGS*WORD_W-1:0] all_q
);
  // Slot FLAG_IDX holds the flag register, so index 111 reads it directly.
  word_t gpr [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) gpr[i] <= '0;
    end else begin
      if (wr_a_en && wr_a_idx != ridx_t'(FLAG_IDX)) gpr[wr_a_idx] <= wr_a_data;
      if (wr_b_en) gpr[REM_IDX] <= wr_b_data;
      if (fl_en) gpr[FLAG_IDX] <= {{(WORD_W-FLAG_W){1'b0}}, fl_data};
    end
  end

  assign rd_a  = gpr[rd_a_idx];
  assign rd_b  = gpr[rd_b_idx];
  assign rd_c  = gpr[rd_c_idx];
  assign flags = gpr[FLAG_IDX][FLAG_W-1:0];

  for (genvar k = 0; k < NREGS; k++) begin : g_snap
    assign all_q[k*WORD_W +: WORD_W] = gpr[k];
  end

  // R8: at most one compare bit, nothing above V
  assert_flag_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gpr[FLAG_IDX][FL_L:FL_E]) <= 1 && gpr[FLAG_IDX][WORD_W-1:FLAG_W] == '0);
endmodule

// File: rtl/mc16_exec.sv
module mc16_exec
  import mc16_pkg::*;
(
  input  word_t             ir,
  input  addr_t             pc,
  input  word_t             src_a,   // register named by ir[5:3]
  input  word_t             src_b,   // register named by ir[2:0]
  input  word_t             src_c,   // register named by ir[10:8]
  input  logic [FLAG_W-1:0] flags,
  input  word_t             mem_q,
  output commit_t           cm
);
  logic [4:0]          op;
  logic [WORD_W:0]     add_r, sub_r, mul_r;
  logic [2*WORD_W:0]   div_r;
  logic [FLAG_W-1:0]   cmp_r;

  assign op    = ir[15:11];
  assign add_r = fn_add(src_a, src_b);
  assign sub_r = fn_sub(src_a, src_b);
  assign mul_r = fn_mul(src_a, src_b);
  assign div_r = fn_div(src_a, src_b);
  assign cmp_r = fn_cmp(src_a, src_b);

  always_comb begin
    cm         = '0;
    cm.npc     = pc + addr_t'(1);
    cm.wa      = ir[10:8];
    cm.st_addr = ir[7:0];
    cm.st_data = src_c;
    case (op)
      OP_ADD: begin cm.we_a = 1'b1; cm.wa = ir[8:6]; cm.da = add_r[WORD_W-1:0]; cm.flags[FL_V] = add_r[WORD_W]; end
      OP_SUB: begin cm.we_a = 1'b1; cm.wa = ir[8:6]; cm.da = sub_r[WORD_W-1:0]; cm.flags[FL_V] = sub_r[WORD_W]; end
      OP_MUL: begin cm.we_a = 1'b1; cm.wa = ir[8:6]; cm.da = mul_r[WORD_W-1:0]; cm.flags[FL_V] = mul_r[WORD_W]; end
      OP_XOR: begin cm.we_a = 1'b1; cm.wa = ir[8:6]; cm.da = src_a ^ src_b; end
      OP_OR:  begin cm.we_a = 1'b1; cm.wa = ir[8:6]; cm.da = src_a | src_b; end
      OP_AND: begin cm.we_a = 1'b1; cm.wa = ir[8:6]; cm.da = src_a & src_b; end
      OP_MOVI: begin cm.we_a = 1'b1; cm.da = {{(WORD_W-8){1'b0}}, ir[7:0]}; end
      OP_SHR: begin cm.we_a = 1'b1; cm.da = src_c >> ir[7:0]; end
      OP_SHL: begin cm.we_a = 1'b1; cm.da = src_c << ir[7:0]; end
      OP_LD:  begin cm.we_a = 1'b1; cm.da = mem_q; end
      OP_ST:  cm.st_en = 1'b1;
      OP_MOVR: begin cm.we_a = 1'b1; cm.wa = ir[5:3]; cm.da = src_b; end
      OP_INV: begin cm.we_a = 1'b1; cm.wa = ir[5:3]; cm.da = ~src_b; end
      OP_DIV: begin
        cm.we_a = 1'b1; cm.wa = ridx_t'(QUOT_IDX); cm.da = div_r[2*WORD_W-1:WORD_W];
        cm.we_b = 1'b1; cm.db = div_r[WORD_W-1:0];
        cm.flags[FL_V] = div_r[2*WORD_W];
      end
      OP_CMP: cm.flags = cmp_r;
      OP_JMP: cm.npc = ir[7:0];
      OP_JLT: if (flags[FL_L]) cm.npc = ir[7:0];
      OP_JGT: if (flags[FL_G]) cm.npc = ir[7:0];
      OP_JEQ: if (flags[FL_E]) cm.npc = ir[7:0];
      OP_HLT: begin cm.stop = 1'b1; cm.npc = pc; end
      default: begin cm.stop = 1'b1; cm.bad = 1'b1; cm.npc = pc; end
    endcase
  end
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_en,
  input  logic [ADDR_W-1:0]       load_addr,
  input  logic [WORD_W-1:0]       load_data,
  input  logic [ADDR_W-1:0]       dump_addr,
  output logic [WORD_W-1:0]       dump_data,
  output logic                    trace_valid,
  output logic [ADDR_W-1:0]       trace_pc,
  output logic [NREGS*WORD_W-1:0] trace_regs,
  output logic                    halted,
  output logic                    illegal
);
  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_WB, S_HALT} state_e;

  state_e            state;
  addr_t             pc;
  word_t             ir;
  commit_t           cm, cm_next;
  word_t             src_a, src_b, src_c, mem_q;
  logic [FLAG_W-1:0] flags;
  addr_t             mem_raddr, mem_waddr;
  word_t             mem_wdata;
  logic              mem_we;
  logic              retire;

  assign retire    = (state == S_WB);
  assign mem_raddr = (state == S_FETCH) ? pc : ir[7:0];
  // load port owns the write side only while reset is held
  assign mem_we    = rst_n ? (retire && cm.st_en) : load_en;
  assign mem_waddr = rst_n ? cm.st_addr : load_addr;
  assign mem_wdata = rst_n ? cm.st_data : load_data;

  mc16_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a(mem_raddr), .rdata_a(mem_q), .raddr_b(dump_addr), .rdata_b(dump_data)
  );

  mc16_regfile u_rf (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(ir[5:3]), .rd_a(src_a),
    .rd_b_idx(ir[2:0]), .rd_b(src_b),
    .rd_c_idx(ir[10:8]), .rd_c(src_c),
    .wr_a_en(retire && cm.we_a), .wr_a_idx(cm.wa), .wr_a_data(cm.da),
    .wr_b_en(retire && cm.we_b), .wr_b_data(cm.db),
    .fl_en(retire), .fl_data(cm.flags),
    .flags(flags), .all_q(trace_regs)
  );

  mc16_exec u_exec (
    .ir(ir), .pc(pc), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .flags(flags), .mem_q(mem_q), .cm(cm_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_FETCH;
      pc          <= '0;
      ir          <= '0;
      cm          <= '0;
      halted      <= 1'b0;
      illegal     <= 1'b0;
      trace_valid <= 1'b0;
      trace_pc    <= '0;
    end else begin
      trace_valid <= 1'b0;
      case (state)
        S_FETCH: begin ir <= mem_q; state <= S_EXEC; end
        S_EXEC:  begin cm <= cm_next; state <= S_WB; end
        S_WB: begin
          pc          <= cm.npc;
          trace_valid <= 1'b1;
          trace_pc    <= pc;
          if (cm.stop) begin
            state   <= S_HALT;
            halted  <= 1'b1;
            illegal <= cm.bad;
          end else begin
            state <= S_FETCH;
          end
        end
        default: state <= S_HALT;
      endcase
    end
  end

  assert_trace_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trace_valid |=> !trace_valid);
  assert_trace_from_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trace_valid |-> $past(state) == S_WB);
  assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !trace_valid);
  assert_no_store_halted_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);
  assert_illegal_stops_R13: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);
endmodule

// File: tb/mc16_core_tb.sv
`timescale 1ns/1ps
module mc16_core_tb;
  localparam logic [4:0] K_ADD = 5'd0, K_SUB = 5'd1, K_MOVI = 5'd2, K_MOVR = 5'd3, K_LD = 5'd4,
                         K_ST = 5'd5, K_MUL = 5'd6, K_DIV = 5'd7, K_SHR = 5'd8, K_SHL = 5'd9,
                         K_XOR = 5'd10, K_OR = 5'd11, K_AND = 5'd12, K_INV = 5'd13, K_CMP = 5'd14,
                         K_JMP = 5'd15, K_JLT = 5'd16, K_JGT = 5'd17, K_JEQ = 5'd18, K_HLT = 5'd19;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0, load_en = 1'b0;
  logic [7:0]   load_addr = '0, dump_addr = '0;
  logic [15:0]  load_data = '0, dump_data;
  logic         trace_valid, halted, illegal;
  logic [7:0]   trace_pc;
  logic [127:0] trace_regs;

  mc16_core u_dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
    .dump_addr(dump_addr), .dump_data(dump_data), .trace_valid(trace_valid), .trace_pc(trace_pc),
    .trace_regs(trace_regs), .halted(halted), .illegal(illegal)
  );

  int checks = 0, fails = 0;
  logic [15:0]  prog [256];
  logic [7:0]   t_pc [64];
  logic [127:0] t_rg [64];
  int           t_cy [64];
  int           nt, dbl;

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rg(int k, int i);
    return t_rg[k][i*16 +: 16];
  endfunction
  function automatic logic [15:0] eA(logic [4:0] op, int a, int b, int c);
    return {op, 2'b00, a[2:0], b[2:0], c[2:0]};
  endfunction
  function automatic logic [15:0] eB(logic [4:0] op, int r, int v);
    return {op, r[2:0], v[7:0]};
  endfunction
  function automatic logic [15:0] eC(logic [4:0] op, int a, int b);
    return {op, 5'b00000, a[2:0], b[2:0]};
  endfunction
  function automatic logic [15:0] eE(logic [4:0] op, int adr);
    return {op, 3'b000, adr[7:0]};
  endfunction

  task automatic clear_prog();
    for (int a = 0; a < 256; a++) prog[a] = '0;
  endtask

  task automatic boot();
    rst_n = 1'b0; load_en = 1'b0;
    repeat (2) @(negedge clk);
    for (int a = 0; a < 256; a++) begin
      load_en = 1'b1; load_addr = a[7:0]; load_data = prog[a];
      @(negedge clk);
    end
    load_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(int max_tr);
    logic prev;
    nt = 0; dbl = 0; prev = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (trace_valid) begin
        if (prev) dbl++;
        if (nt < 64) begin t_pc[nt] = trace_pc; t_rg[nt] = trace_regs; t_cy[nt] = c; end
        nt++;
      end
      prev = trace_valid;
      if (halted || nt >= max_tr) return;
    end
    chk("R12", "program did not stop", 0, 1);
  endtask

  task automatic t_reset();
    clear_prog();
    prog[0] = eB(K_MOVI, 1, 7);
    prog[1] = {K_HLT, 11'b0};
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "halted in reset", halted, 0);
    chk("R1", "illegal in reset", illegal, 0);
    chk("R1", "trace_valid in reset", trace_valid, 0);
    boot();
    chk("R1", "registers after reset", trace_regs, 0);
    run(8);
    chk("R1", "trace count", nt, 2);
    chk("R1", "first pc", t_pc[0], 0);
    chk("R5", "mov imm R1", rg(0, 1), 7);
    chk("R3", "three cycles per instruction", t_cy[1] - t_cy[0], 3);
    chk("R3", "strobe width", dbl, 0);
  endtask

  task automatic t_arith();
    clear_prog();
    prog[0] = eB(K_MOVI, 1, 10);   prog[1] = eB(K_MOVI, 2, 100);
    prog[2] = eA(K_MUL, 3, 1, 2);  prog[3] = eB(K_MOVI, 4, 255);
    prog[4] = eB(K_SHL, 4, 8);     prog[5] = eA(K_ADD, 5, 4, 4);
    prog[6] = eA(K_SUB, 6, 1, 2);  prog[7] = eA(K_SUB, 6, 2, 1);
    prog[8] = eA(K_MUL, 0, 4, 4);  prog[9] = {K_HLT, 11'b0};
    boot();
    run(20);
    chk("R3", "trace count", nt, 10);
    for (int k = 0; k < 10; k++) chk("R11", "sequential pc", t_pc[k], k);
    chk("R4", "mul 10*100", rg(2, 3), 1000);
    chk("R4", "mul no overflow flag", rg(2, 7), 0);
    chk("R6", "shift left 8", rg(4, 4), 16'hFF00);
    chk("R4", "add wraps", rg(5, 5), (32'hFF00 * 2) & 32'hFFFF);
    chk("R4", "add carry sets V", rg(5, 7), 8);
    chk("R4", "sub underflow clamps", rg(6, 6), 0);
    chk("R4", "sub underflow sets V", rg(6, 7), 8);
    chk("R4", "sub 100-10", rg(7, 6), 90);
    chk("R4", "sub clears V", rg(7, 7), 0);
    chk("R4", "mul low half", rg(8, 0), (32'hFF00 * 32'hFF00) & 32'hFFFF);
    chk("R4", "mul overflow V", rg(8, 7), 8);
    chk("R9", "halt clears flags", rg(9, 7), 0);
    chk("R12", "halted", halted, 1);
    chk("R13", "no illegal on hlt", illegal, 0);
    chk("R3", "strobe width", dbl, 0);
    begin
      int extra = 0;
      for (int c = 0; c < 12; c++) begin @(negedge clk); if (trace_valid) extra++; end
      chk("R12", "no trace after halt", extra, 0);
      chk("R12", "halted holds", halted, 1);
    end
  endtask

  task automatic t_logic();
    clear_prog();
    prog[0]  = eB(K_MOVI, 1, 8'hF0); prog[1]  = eB(K_MOVI, 2, 8'h3C);
    prog[2]  = eA(K_XOR, 3, 1, 2);   prog[3]  = eA(K_OR, 4, 1, 2);
    prog[4]  = eA(K_AND, 5, 1, 2);   prog[5]  = eC(K_INV, 6, 1);
    prog[6]  = eB(K_SHR, 1, 4);      prog[7]  = eC(K_MOVR, 0, 6);
    prog[8]  = eC(K_CMP, 1, 2);      prog[9]  = eC(K_MOVR, 0, 7);
    prog[10] = eC(K_CMP, 2, 1);      prog[11] = eC(K_CMP, 2, 2);
    prog[12] = eB(K_SHL, 2, 20);     prog[13] = eB(K_MOVI, 6, 5);
    prog[14] = {K_HLT, 11'b0};
    boot();
    run(30);
    chk("R3", "trace count", nt, 15);
    chk("R6", "xor", rg(2, 3), 16'h00CC);
    chk("R6", "or", rg(3, 4), 16'h00FC);
    chk("R6", "and", rg(4, 5), 16'h0030);
    chk("R6", "not", rg(5, 6), 16'hFF0F);
    chk("R6", "shift right 4", rg(6, 1), 16'h000F);
    chk("R5", "mov reg", rg(7, 0), 16'hFF0F);
    chk("R8", "cmp less", rg(8, 7), 4);
    chk("R5", "mov from FLAGS", rg(9, 0), 4);
    chk("R9", "mov clears flags", rg(9, 7), 0);
    chk("R8", "cmp greater", rg(10, 7), 2);
    chk("R8", "cmp equal", rg(11, 7), 1);
    chk("R6", "shift past width", rg(12, 2), 0);
    chk("R9", "shift clears flags", rg(12, 7), 0);
    chk("R5", "mov imm zero-extends", rg(13, 6), 5);
  endtask

  task automatic t_div();
    clear_prog();
    prog[0] = eB(K_MOVI, 2, 200); prog[1] = eB(K_MOVI, 3, 7);
    prog[2] = eC(K_DIV, 2, 3);    prog[3] = eB(K_MOVI, 4, 0);
    prog[4] = eC(K_DIV, 2, 4);    prog[5] = {K_HLT, 11'b0};
    boot();
    run(10);
    chk("R7", "quotient", rg(2, 0), 200 / 7);
    chk("R7", "remainder", rg(2, 1), 200 % 7);
    chk("R7", "div flags", rg(2, 7), 0);
    chk("R7", "div0 quotient", rg(4, 0), 0);
    chk("R7", "div0 remainder", rg(4, 1), 0);
    chk("R7", "div0 sets V", rg(4, 7), 8);
  endtask

  task automatic t_mem();
    clear_prog();
    prog[0] = eB(K_LD, 1, 100);   prog[1] = eB(K_MOVI, 2, 8'h55);
    prog[2] = eB(K_ST, 2, 101);   prog[3] = eB(K_ST, 1, 102);
    prog[4] = {K_HLT, 11'b0};
    prog[100] = 16'hBEEF;
    boot();
    run(10);
    chk("R10", "load word", rg(0, 1), 16'hBEEF);
    dump_addr = 8'd101; #1;
    chk("R10", "store word 101", dump_data, 16'h0055);
    dump_addr = 8'd102; #1;
    chk("R10", "store word 102", dump_data, 16'hBEEF);
    dump_addr = 8'd100; #1;
    chk("R2", "loaded word", dump_data, 16'hBEEF);
    @(negedge clk);
    load_en = 1'b1; load_addr = 8'd101; load_data = 16'h1234;
    repeat (3) @(negedge clk);
    load_en = 1'b0;
    dump_addr = 8'd101; #1;
    chk("R2", "load ignored while running", dump_data, 16'h0055);
  endtask

  task automatic t_jump();
    int exp_pc [14] = '{0, 1, 2, 3, 4, 5, 10, 11, 14, 15, 17, 18, 19, 22};
    clear_prog();
    prog[0]  = eB(K_MOVI, 1, 5);  prog[1]  = eB(K_MOVI, 2, 9);
    prog[2]  = eC(K_CMP, 1, 2);   prog[3]  = eE(K_JGT, 20);
    prog[4]  = eC(K_CMP, 1, 2);   prog[5]  = eE(K_JLT, 10);
    prog[10] = eC(K_CMP, 2, 2);   prog[11] = eE(K_JEQ, 14);
    prog[14] = eC(K_CMP, 2, 1);   prog[15] = eE(K_JGT, 17);
    prog[17] = eB(K_MOVI, 3, 1);  prog[18] = eE(K_JLT, 30);
    prog[19] = eE(K_JMP, 22);     prog[20] = {K_HLT, 11'b0};
    prog[22] = {K_HLT, 11'b0};    prog[30] = {K_HLT, 11'b0};
    boot();
    run(30);
    chk("R11", "trace count", nt, 14);
    for (int k = 0; k < 14; k++) chk("R11", "branch path pc", t_pc[k], exp_pc[k]);
    chk("R9", "taken jlt clears flags", rg(5, 7), 0);
    chk("R9", "taken jgt clears flags", rg(9, 7), 0);
  endtask

  task automatic t_wrap();
    clear_prog();
    prog[0]   = eE(K_JMP, 255);
    prog[255] = eB(K_MOVI, 1, 3);
    boot();
    run(3);
    chk("R11", "wrap trace count", nt, 3);
    chk("R11", "jump target", t_pc[1], 255);
    chk("R11", "pc wraps to 0", t_pc[2], 0);
  endtask

  task automatic t_illegal();
    clear_prog();
    prog[0] = eB(K_MOVI, 1, 1);
    prog[1] = 16'b10101_000_0000_0011;
    boot();
    run(10);
    chk("R13", "trace count", nt, 2);
    chk("R13", "illegal pc", t_pc[1], 1);
    chk("R13", "illegal raised", illegal, 1);
    chk("R13", "halted on illegal", halted, 1);
    chk("R13", "registers untouched", rg(1, 1), 1);
    begin
      int extra = 0;
      for (int c = 0; c < 20; c++) begin @(negedge clk); if (trace_valid) extra++; end
      chk("R12", "silent after illegal", extra, 0);
      chk("R13", "illegal holds", illegal, 1);
    end
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_arith();
    t_logic();
    t_div();
    t_mem();
    t_jump();
    t_wrap();
    t_illegal();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule